// File: doc/BRIEF.md
# Instruction Queue Dispatch Gate

This block is a six-entry instruction queue with its dispatch decision. Fetch offers up to four decoded instructions per cycle. Each instruction carries a tag, a target unit code, an operands-ready bit and the number of destination registers it writes. The queue takes as many of them as it has room for after this cycle's departures. Every cycle the gate looks at the two oldest entries and decides, in program order, which of them may leave for the back end.

A candidate leaves only when four resource rules hold. The first is a free reservation station entry, or a free pipeline slot for direct issue. The second is a completion queue entry. The third is enough free rename registers. The fourth is that every older instruction also leaves. The back end is visible only as counts and flags at the ports. When both candidates are checked in one cycle, the younger one sees the station entries, pipeline slots and rename registers that the older one has just claimed.

Top module: `iq_dispatch_gate`

## Requirements
- R1: Dispatch is in program order. Slot 1 (second oldest) never dispatches in a cycle where slot 0 (oldest) does not.
- R2: A candidate sent to a reservation station needs that unit's free count to exceed the entries already claimed this cycle by the older candidate.
- R3: A candidate with operands ready goes direct to its unit when three conditions hold: the unit's slot flag is set, no older candidate took that slot this cycle, and the station is empty. Empty means the free count equals capacity and nothing was claimed this cycle. Direct issue is preferred over a station entry. `disp_direct` marks it.
- R4: Slot k dispatches only if `cq_free` > k. `cq_alloc` equals the number dispatched.
- R5: The destination counts of the dispatched candidates, summed in order, must not exceed `ren_free`. `ren_alloc` reports that sum.
- R6: The queue holds at most 6 entries. Fetch lanes 0..`fetch_cnt`-1 are offered, with at most 4 counted. `fetch_taken` = min(offered, 6 - count + dispatched). `iq_count` reports the occupancy.
- R7: At most two instructions dispatch per cycle, and only from the two oldest entries.
- R8: Unit codes are 0 branch, 1 simple integer, 2 complex integer, 3 floating point and 4 load/store. The station capacities are 0, 1, 1, 1 and 2. A branch can only go direct. A code of 5 or above never dispatches.
- R9: Survivors shift down by the dispatch count. Accepted fetch lanes fill in behind them, oldest lane first, in the same cycle.
- R10: `flush` suppresses all dispatch and fetch acceptance in its cycle and empties the queue at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue, block dispatch |
| fetch_cnt | input | 3 | Number of valid fetch lanes |
| fetch_tag | input | 32 | Per-lane tag, 8 bits each |
| fetch_unit | input | 12 | Per-lane unit code, 3 bits each |
| fetch_rdy | input | 4 | Per-lane operands-ready |
| fetch_ndst | input | 8 | Per-lane destination count, 2 bits each |
| rs_free | input | 10 | Per-unit free station entries, 2 bits each |
| slot_free | input | 5 | Per-unit pipeline slot free |
| cq_free | input | 3 | Free completion queue entries |
| ren_free | input | 3 | Free rename registers |
| fetch_taken | output | 3 | Fetch lanes accepted this cycle |
| iq_count | output | 3 | Queue occupancy |
| disp_valid | output | 2 | Dispatch strobe per slot |
| disp_direct | output | 2 | Slot issues direct to its unit |
| disp_tag | output | 16 | Tag per slot |
| disp_unit | output | 6 | Target unit per slot |
| cq_alloc | output | 2 | Completion entries allocated |
| ren_alloc | output | 3 | Rename registers allocated |

## Verification
The dispatch strobes, direct flags, allocation counts and `fetch_taken` are combinational in the queue contents and the resource inputs. They are due in the same cycle the inputs are applied. The bench drives at the falling edge and samples one nanosecond later, before the rising edge. Queue occupancy and the new head entries appear one rising edge after the cycle that popped or pushed. They are sampled in the following low phase. Each sweep trial first loads two entries while the completion queue reports no room. It then applies the resources and compares the results against a model of R1 to R8.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
    localparam int TAG_W     = 8;
    localparam int UNIT_W    = 3;
    localparam int NUM_UNITS = 5;
    localparam int NDST_W    = 2;
    localparam int DEPTH     = 6;
    localparam int FETCH_W   = 4;
    localparam int NCAND     = 2;
    localparam int RS_W      = 2;
    localparam int CQ_W      = 3;
    localparam int REN_W     = 3;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int POP_W     = $clog2(NCAND + 1);

    typedef enum logic [UNIT_W-1:0] {
        U_BR  = 3'd0,
        U_SIU = 3'd1,
        U_CIU = 3'd2,
        U_FPU = 3'd3,
        U_LSU = 3'd4
    } unit_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [UNIT_W-1:0] unit;
        logic              rdy;
        logic [NDST_W-1:0] ndst;
    } iq_entry_t;

    typedef struct packed {
        logic [NUM_UNITS-1:0]           slot_used;
        logic [NUM_UNITS-1:0][RS_W-1:0] rs_used;
        logic [REN_W-1:0]               ren_used;
    } claim_t;

    function automatic logic [RS_W-1:0] rs_cap(input logic [UNIT_W-1:0] u);
        case (u)
            U_BR:    return RS_W'(0);
            U_LSU:   return RS_W'(2);
            default: return RS_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/iqd_queue.sv
module iqd_queue
    import iqd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic [POP_W-1:0]     n_pop,
    input  logic [CNT_W-1:0]     fetch_cnt,
    input  iq_entry_t            fetch_ent [FETCH_W],
    output iq_entry_t            head [NCAND],
    output logic [NCAND-1:0]     head_present,
    output logic [CNT_W-1:0]     count,
    output logic [CNT_W-1:0]     taken
);
    iq_entry_t        q   [DEPTH];
    iq_entry_t        q_n [DEPTH];
    logic [CNT_W-1:0] cnt_n, keep, room, want;
    int               src, lane;

    always_comb begin
        keep  = count - CNT_W'(n_pop);
        room  = CNT_W'(DEPTH) - keep;
        want  = (fetch_cnt > CNT_W'(FETCH_W)) ? CNT_W'(FETCH_W) : fetch_cnt;
        taken = flush ? '0 : ((want < room) ? want : room);
        src   = 0;
        lane  = 0;
        for (int i = 0; i < DEPTH; i++) begin
            q_n[i] = q[i];
            src    = i + int'(n_pop);
            lane   = i - int'(keep);
            if (src < int'(count))
                q_n[i] = q[src];
            else if (lane >= 0 && lane < int'(taken))
                q_n[i] = fetch_ent[lane];
        end
        cnt_n = flush ? '0 : keep + taken;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= cnt_n;
        for (int i = 0; i < DEPTH; i++) q[i] <= q_n[i];
    end

    generate
        for (genvar k = 0; k < NCAND; k++) begin : g_head
            assign head[k]         = q[k];
            assign head_present[k] = (count > CNT_W'(k));
        end
    endgenerate

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_count_track_R9: assert property (@(posedge clk) disable iff (rst)
        !flush |=> count == $past(count) - CNT_W'($past(n_pop)) + $past(taken));
    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == '0);
endmodule

// File: rtl/iqd_rule_check.sv
module iqd_rule_check
    import iqd_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  iq_entry_t                      entry,
    input  logic                           present,
    input  logic                           older_ok,
    input  logic [NUM_UNITS-1:0][RS_W-1:0] rs_free,
    input  logic [NUM_UNITS-1:0]           slot_free,
    input  logic [CQ_W-1:0]                cq_free,
    input  logic [REN_W-1:0]               ren_free,
    input  claim_t                         claim_in,
    output logic                           go,
    output logic                           direct,
    output claim_t                         claim_out
);
    logic                 in_range, st_empty, dir_ok, rs_ok, cq_ok, ren_ok;
    logic [UNIT_W-1:0]    uidx;
    logic [RS_W-1:0]      cap, free, held;
    logic [REN_W:0]       need;

    always_comb begin
        in_range = entry.unit < UNIT_W'(NUM_UNITS);
        uidx     = in_range ? entry.unit : '0;
        cap      = rs_cap(entry.unit);
        free     = rs_free[uidx];
        held     = claim_in.rs_used[uidx];
        st_empty = (free == cap) && (held == '0);
        dir_ok   = entry.rdy && slot_free[uidx] && !claim_in.slot_used[uidx] && st_empty;
        rs_ok    = (cap != '0) && (free > held);
        cq_ok    = cq_free > CQ_W'(SLOT);
        need     = {1'b0, claim_in.ren_used} + (REN_W+1)'(entry.ndst);
        ren_ok   = {1'b0, ren_free} >= need;
        go       = present && older_ok && in_range && (dir_ok || rs_ok) && cq_ok && ren_ok;
        direct   = go && dir_ok;
        claim_out = claim_in;
        if (go) begin
            if (dir_ok) claim_out.slot_used[uidx] = 1'b1;
            else        claim_out.rs_used[uidx]   = held + RS_W'(1);
            claim_out.ren_used = REN_W'(need);
        end
    end

    assert_rs_room_R2: assert property (@(posedge clk) disable iff (rst)
        (go && !direct) |-> rs_free[uidx] > claim_in.rs_used[uidx]);
    assert_cq_room_R4: assert property (@(posedge clk) disable iff (rst)
        go |-> cq_free > CQ_W'(SLOT));
    assert_direct_empty_R3: assert property (@(posedge clk) disable iff (rst)
        direct |-> (rs_free[uidx] == rs_cap(entry.unit)) && slot_free[uidx]);
endmodule

// File: rtl/iq_dispatch_gate.sv
module iq_dispatch_gate
    import iqd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic [CNT_W-1:0]            fetch_cnt,
    input  logic [FETCH_W*TAG_W-1:0]    fetch_tag,
    input  logic [FETCH_W*UNIT_W-1:0]   fetch_unit,
    input  logic [FETCH_W-1:0]          fetch_rdy,
    input  logic [FETCH_W*NDST_W-1:0]   fetch_ndst,
    input  logic [NUM_UNITS*RS_W-1:0]   rs_free,
    input  logic [NUM_UNITS-1:0]        slot_free,
    input  logic [CQ_W-1:0]             cq_free,
    input  logic [REN_W-1:0]            ren_free,
    output logic [CNT_W-1:0]            fetch_taken,
    output logic [CNT_W-1:0]            iq_count,
    output logic [NCAND-1:0]            disp_valid,
    output logic [NCAND-1:0]            disp_direct,
    output logic [NCAND*TAG_W-1:0]      disp_tag,
    output logic [NCAND*UNIT_W-1:0]     disp_unit,
    output logic [POP_W-1:0]            cq_alloc,
    output logic [REN_W-1:0]            ren_alloc
);
    iq_entry_t                      fetch_ent [FETCH_W];
    iq_entry_t                      head [NCAND];
    logic [NCAND-1:0]               head_present;
    logic [NUM_UNITS-1:0][RS_W-1:0] rs_arr;
    claim_t                         claim [NCAND+1];
    logic [NCAND:0]                 ok_chain;
    logic [POP_W-1:0]               n_pop;

    assign rs_arr      = rs_free;
    assign claim[0]    = '0;
    assign ok_chain[0] = !flush;

    generate
        for (genvar j = 0; j < FETCH_W; j++) begin : g_lane
            assign fetch_ent[j].tag  = fetch_tag[j*TAG_W +: TAG_W];
            assign fetch_ent[j].unit = fetch_unit[j*UNIT_W +: UNIT_W];
            assign fetch_ent[j].rdy  = fetch_rdy[j];
            assign fetch_ent[j].ndst = fetch_ndst[j*NDST_W +: NDST_W];
        end

        for (genvar k = 0; k < NCAND; k++) begin : g_cand
            iqd_rule_check #(.SLOT(k)) u_chk (
                .clk       (clk),
                .rst       (rst),
                .entry     (head[k]),
                .present   (head_present[k]),
                .older_ok  (ok_chain[k]),
                .rs_free   (rs_arr),
                .slot_free (slot_free),
                .cq_free   (cq_free),
                .ren_free  (ren_free),
                .claim_in  (claim[k]),
                .go        (ok_chain[k+1]),
                .direct    (disp_direct[k]),
                .claim_out (claim[k+1])
            );
            assign disp_valid[k]                = ok_chain[k+1];
            assign disp_tag[k*TAG_W +: TAG_W]   = head[k].tag;
            assign disp_unit[k*UNIT_W +: UNIT_W] = head[k].unit;
        end
    endgenerate

    always_comb begin
        n_pop = '0;
        for (int k = 0; k < NCAND; k++) n_pop = n_pop + POP_W'(disp_valid[k]);
    end

    iqd_queue u_queue (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .n_pop        (n_pop),
        .fetch_cnt    (fetch_cnt),
        .fetch_ent    (fetch_ent),
        .head         (head),
        .head_present (head_present),
        .count        (iq_count),
        .taken        (fetch_taken)
    );

    assign cq_alloc  = n_pop;
    assign ren_alloc = claim[NCAND].ren_used;

    assert_in_order_R1: assert property (@(posedge clk) disable iff (rst)
        disp_valid[1] |-> disp_valid[0]);
    assert_cq_budget_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(disp_valid) <= int'(cq_free));
    assert_ren_budget_R5: assert property (@(posedge clk) disable iff (rst)
        ren_alloc <= ren_free);
    assert_from_head_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(disp_valid) <= int'(iq_count));
    assert_branch_direct_R8: assert property (@(posedge clk) disable iff (rst)
        (disp_valid[0] && disp_unit[UNIT_W-1:0] == U_BR) |-> disp_direct[0]);
    assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        flush |-> (disp_valid == '0) && (fetch_taken == '0));
endmodule

// File: tb/sim_iq_dispatch_gate.sv
`timescale 1ns/1ps
module sim_iq_dispatch_gate;
    logic        clk = 1'b0;
    logic        rst, flush;
    logic [2:0]  fetch_cnt;
    logic [31:0] fetch_tag;
    logic [11:0] fetch_unit;
    logic [3:0]  fetch_rdy;
    logic [7:0]  fetch_ndst;
    logic [9:0]  rs_free;
    logic [4:0]  slot_free;
    logic [2:0]  cq_free, ren_free;
    logic [2:0]  fetch_taken, iq_count;
    logic [1:0]  disp_valid, disp_direct;
    logic [15:0] disp_tag;
    logic [5:0]  disp_unit;
    logic [1:0]  cq_alloc;
    logic [2:0]  ren_alloc;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    iq_dispatch_gate u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_lane(input int j, input int tag, input int unit, input bit rdy, input int nd);
        fetch_tag[j*8 +: 8]  = 8'(tag);
        fetch_unit[j*3 +: 3] = 3'(unit);
        fetch_rdy[j]         = rdy;
        fetch_ndst[j*2 +: 2] = 2'(nd);
    endtask

    function automatic int cap_of(input int u);
        return (u == 0) ? 0 : (u == 4) ? 2 : 1;
    endfunction

    // model of R1..R8: returns {valid, direct, cq_alloc, ren_alloc}
    function automatic int model(input int u0_, input bit r0, input int d0,
                                 input int u1_, input bit r1, input int d1);
        int used_rs[5], used_sl[5], ren_u, uu, nd, cp, fr;
        bit rdy, ok, dir, rsok;
        int v, dr, n;
        v = 0; dr = 0; n = 0; ren_u = 0; ok = 1;
        for (int u = 0; u < 5; u++) begin used_rs[u] = 0; used_sl[u] = 0; end
        for (int k = 0; k < 2; k++) begin
            uu = (k == 0) ? u0_ : u1_;
            rdy = (k == 0) ? r0 : r1;
            nd = (k == 0) ? d0 : d1;
            if (uu >= 5) ok = 0;
            if (ok) begin
                cp = cap_of(uu);
                fr = int'(rs_free[uu*2 +: 2]);
                dir = rdy && slot_free[uu] && used_sl[uu] == 0 && fr == cp && used_rs[uu] == 0;
                rsok = cp > 0 && fr > used_rs[uu];
                ok = (dir || rsok) && int'(cq_free) > k && int'(ren_free) >= ren_u + nd;
                if (ok) begin
                    v |= (1 << k); n++; ren_u += nd;
                    if (dir) begin dr |= (1 << k); used_sl[uu] = 1; end
                    else used_rs[uu]++;
                end
            end
        end
        return (v << 7) | (dr << 5) | (n << 3) | ren_u;
    endfunction

    function automatic int got();
        return (int'(disp_valid) << 7) | (int'(disp_direct) << 5) | (int'(cq_alloc) << 3) | int'(ren_alloc);
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; flush = 0; fetch_cnt = 0; fetch_tag = 0; fetch_unit = 0; fetch_rdy = 0;
        fetch_ndst = 0; rs_free = 0; slot_free = 0; cq_free = 0; ren_free = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // reset state
        check("R6 reset count", int'(iq_count), 0);
        check("R7 reset no dispatch", int'(disp_valid), 0);
        check("R6 reset fetch_taken", int'(fetch_taken), 0);

        // R6 capacity: fill with completion queue closed
        @(negedge clk);
        for (int j = 0; j < 4; j++) set_lane(j, 10 + j, 1, 1, 1);
        fetch_cnt = 4;
        #1 check("R6 take four", int'(fetch_taken), 4);
        @(negedge clk);
        for (int j = 0; j < 4; j++) set_lane(j, 14 + j, 1, 1, 1);
        #1 check("R6 room for two", int'(fetch_taken), 2);
        check("R6 count four", int'(iq_count), 4);
        @(negedge clk);
        fetch_cnt = 3;
        #1 check("R6 full takes none", int'(fetch_taken), 0);
        check("R6 count six", int'(iq_count), 6);

        // R9 shift by one with refill
        @(negedge clk);
        rs_free = {2'd2, 2'd1, 2'd1, 2'd1, 2'd0}; slot_free = 5'h1f; ren_free = 6; cq_free = 1;
        for (int j = 0; j < 4; j++) set_lane(j, 16 + j, 1, 1, 1);
        fetch_cnt = 4;
        #1 check("R4 one cq entry", int'(disp_valid), 1);
        check("R3 direct when empty", int'(disp_direct), 1);
        check("R9 refill one", int'(fetch_taken), 1);
        check("R7 oldest tag", int'(disp_tag[7:0]), 10);
        @(negedge clk);
        fetch_cnt = 0; cq_free = 2;
        #1 check("R9 count after shift", int'(iq_count), 6);
        check("R9 new head", int'(disp_tag[7:0]), 11);
        check("R7 second tag", int'(disp_tag[15:8]), 12);
        check("R2 slot taken goes to station", int'(disp_valid), 3);
        check("R3 only older direct", int'(disp_direct), 1);
        check("R5 ren sum", int'(ren_alloc), 2);
        @(negedge clk);
        cq_free = 0;
        #1 check("R9 count after two", int'(iq_count), 4);
        check("R9 head after two", int'(disp_tag[7:0]), 13);

        // R10 flush
        @(negedge clk);
        flush = 1; cq_free = 2; fetch_cnt = 2;
        #1 check("R10 no dispatch", int'(disp_valid), 0);
        check("R10 no fetch", int'(fetch_taken), 0);
        @(negedge clk);
        flush = 0; fetch_cnt = 0; cq_free = 0;
        #1 check("R10 emptied", int'(iq_count), 0);

        // sweep R1..R8
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int r = 0; r < 4; r++)
                    for (int rep = 0; rep < 4; rep++) begin
                        int d0, d1, e;
                        d0 = $urandom % 3; d1 = $urandom % 3;
                        @(negedge clk);
                        flush = 1; cq_free = 0; fetch_cnt = 0;
                        @(negedge clk);
                        flush = 0;
                        set_lane(0, 8'hA0, a, r[0], d0);
                        set_lane(1, 8'hA1, b, r[1], d1);
                        fetch_cnt = 2;
                        @(negedge clk);
                        fetch_cnt = 0;
                        for (int u = 0; u < 5; u++)
                            rs_free[u*2 +: 2] = 2'($urandom % (cap_of(u) + 1));
                        slot_free = 5'($urandom);
                        cq_free = 3'($urandom % 3);
                        ren_free = 3'($urandom % 5);
                        #1;
                        e = model(a, r[0], d0, b, r[1], d1);
                        check("R1/R2/R3/R4/R5/R8 sweep", got(), e);
                        if (rep == 0) begin
                            check("R6 sweep count", int'(iq_count), 2);
                            check("R7 sweep tag", int'(disp_tag), 16'hA1A0);
                        end
                    end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule